// File: doc/BRIEF.md
# Motor Drive Mode Controller

This block is the mode sequencer of a three-phase motor drive. It watches three asynchronous control pins (direction, brake, drive-off), each with its own register override, together with the measured rotor speed, the commanded speed and a programmable brake speed threshold. From these it decides the drive mode (coast, restart, run, decelerate-to-brake, brake), whether the power switches may be driven, which speed the downstream loop should aim for, and in which order the three phases are commutated.

Drive-off has the highest priority and forces coast from any mode. Brake comes next and is a two-step sequence: the speed target drops to the brake threshold, and the brake mode is entered only once the measured speed is at or below it. Run is the lowest priority. Leaving coast or brake always goes through a timed restart, as from standstill. A new direction is taken only in modes where the rotor is not being actively driven in sequence, so the commutation order never flips mid-rotation.

Top module: `motor_mode_ctrl`

## Requirements
- R1: After a synchronous reset the mode is coast, `drive_en` is 0, `speed_target` is 0 and the phase order is forward.
- R2: Each pin passes through a two-flop synchronizer: a pin change can affect the mode no earlier than the third rising clock edge after it.
- R3: While the synchronized drive-off is high the mode becomes coast from any mode on the next edge, with `drive_en` 0 and `speed_target` 0. A brake request during coast does not leave coast.
- R4: When drive-off is low in coast the mode goes to restart. Restart lasts RESTART_CYC cycles and then goes to run, unless brake is requested, which moves it to decelerate. In restart and run `speed_target` equals `speed_cmd`.
- R5: With brake requested in run, the mode goes to decelerate with `speed_target` equal to `brake_thresh`. It moves to brake only on an edge where `speed_meas <= brake_thresh`. In brake `speed_target` is 0.
- R6: The mode stays in brake for as long as the effective brake request stays high.
- R7: If the brake request drops during decelerate, the mode returns to run. If it drops during brake, the mode goes to restart.
- R8: When `brake_ovr_en` is 1, `brake_ovr_val` replaces the synchronized brake pin. When `dir_ovr_en` is 1, `dir_ovr_val` replaces the synchronized direction pin. The override inputs are not synchronized.
- R9: `phase_order` holds three 2-bit phase codes (A=0, B=1, C=2), with the first phase in bits [5:4]. Direction 1 gives A,B,C (6'b000110). Direction 0 gives A,C,B (6'b001001).
- R10: The effective direction is latched only on edges where the mode is coast, brake or restart. In run and decelerate the phase order holds.
- R11: `mode` is one-hot: bit0 coast, bit1 run, bit2 decelerate, bit3 brake, bit4 restart. `drive_en` is 1 in every mode except coast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_pin | input | 1 | Direction pin, asynchronous |
| brake_pin | input | 1 | Brake pin, asynchronous |
| drvoff_pin | input | 1 | Drive-off pin, asynchronous |
| dir_ovr_en | input | 1 | Select register value for direction |
| dir_ovr_val | input | 1 | Register direction value |
| brake_ovr_en | input | 1 | Select register value for brake |
| brake_ovr_val | input | 1 | Register brake value |
| speed_meas | input | SPD_W | Measured speed |
| speed_cmd | input | SPD_W | Commanded speed |
| brake_thresh | input | SPD_W | Speed at or below which brake may engage |
| mode | output | 5 | One-hot drive mode |
| drive_en | output | 1 | Power switches may be driven |
| speed_target | output | SPD_W | Speed request to the speed loop |
| phase_order | output | 6 | Commutation order, three 2-bit codes |

## Verification
The hardest situation to reach is a brake request that is pending while drive-off holds the block in coast. After drive-off is released, the request must go through restart into decelerate and not straight into brake. The stimulus raises drive-off while the drive is running, asserts brake during coast, and then drops drive-off with brake still held. Direction changes are applied in each mode, in brake and during run, so that both the latching and the holding of the phase order are seen. A randomized phase then toggles pins, overrides and measured speed around the threshold against the cycle model.

// File: rtl/motor_mode_ctrl.sv
module motor_mode_ctrl #(
  parameter int SPD_W       = 16,
  parameter int RESTART_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_pin,
  input  logic             brake_pin,
  input  logic             drvoff_pin,
  input  logic             dir_ovr_en,
  input  logic             dir_ovr_val,
  input  logic             brake_ovr_en,
  input  logic             brake_ovr_val,
  input  logic [SPD_W-1:0] speed_meas,
  input  logic [SPD_W-1:0] speed_cmd,
  input  logic [SPD_W-1:0] brake_thresh,
  output logic [4:0]       mode,
  output logic             drive_en,
  output logic [SPD_W-1:0] speed_target,
  output logic [5:0]       phase_order
);
  localparam int CW = $clog2(RESTART_CYC + 1);

  typedef enum logic [4:0] {
    COAST   = 5'b00001,
    RUN     = 5'b00010,
    DECEL   = 5'b00100,
    BRAKE   = 5'b01000,
    RESTART = 5'b10000
  } mode_t;

  mode_t st, st_nx;
  logic [2:0] s1, s2;
  logic [CW-1:0] cnt;
  logic dir_q;

  wire off_s   = s2[0];
  wire brk_eff = brake_ovr_en ? brake_ovr_val : s2[1];
  wire dir_eff = dir_ovr_en ? dir_ovr_val : s2[2];
  wire at_thr  = speed_meas <= brake_thresh;
  wire rs_done = cnt == CW'(RESTART_CYC - 1);
  wire dir_ld  = st == COAST || st == BRAKE || st == RESTART;

  always_comb begin
    st_nx = st;
    if (off_s) st_nx = COAST;
    else begin
      case (st)
        COAST:   st_nx = RESTART;
        RESTART: if (brk_eff) st_nx = DECEL; else if (rs_done) st_nx = RUN;
        RUN:     if (brk_eff) st_nx = DECEL;
        DECEL:   if (!brk_eff) st_nx = RUN; else if (at_thr) st_nx = BRAKE;
        BRAKE:   if (!brk_eff) st_nx = RESTART;
        default: st_nx = COAST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
      st <= COAST;
      cnt <= '0;
      dir_q <= 1'b1;
    end else begin
      s1 <= {dir_pin, brake_pin, drvoff_pin};
      s2 <= s1;
      st <= st_nx;
      cnt <= (st == RESTART) ? cnt + 1'b1 : '0;
      if (dir_ld) dir_q <= dir_eff;
    end
  end

  assign mode        = st;
  assign drive_en    = st != COAST;
  assign phase_order = dir_q ? 6'b00_01_10 : 6'b00_10_01;
  always_comb begin
    case (st)
      RUN, RESTART: speed_target = speed_cmd;
      DECEL:        speed_target = brake_thresh;
      default:      speed_target = '0;
    endcase
  end

  // R11
  mode_onehot_chk: assert property (@(posedge clk) disable iff (rst) $countones(mode) == 1);
  // R3
  drvoff_coast_chk: assert property (@(posedge clk) disable iff (rst) off_s |=> (mode == 5'b00001 && !drive_en));
  // R5
  brake_needs_thr_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 5'b00100 && !at_thr) |=> mode != 5'b01000);
  // R6
  brake_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 5'b01000 && brk_eff && !off_s) |=> mode == 5'b01000);
  // R10
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 5'b00010 || mode == 5'b00100) |=> $stable(phase_order));
endmodule

// File: tb/tb_motor_mode_ctrl.sv
module tb_motor_mode_ctrl;
  localparam int CLK_PER = 10;
  localparam int W = 16;
  localparam int RC = 16;

  logic clk = 0, rst = 1;
  logic dir_pin = 0, brake_pin = 0, drvoff_pin = 0;
  logic dir_ovr_en = 0, dir_ovr_val = 0, brake_ovr_en = 0, brake_ovr_val = 0;
  logic [W-1:0] speed_meas = 2000, speed_cmd = 1000, brake_thresh = 300;
  logic [4:0] mode;
  logic drive_en;
  logic [W-1:0] speed_target;
  logic [5:0] phase_order;

  int errors = 0, checks = 0, cycles = 0;

  motor_mode_ctrl #(.SPD_W(W), .RESTART_CYC(RC)) dut (.*);

  always #(CLK_PER/2) clk = ~clk;

  // model: 0 coast,1 run,2 decel,3 brake,4 restart
  int m_st = 0, m_cnt = 0, m_dir = 1;
  bit q_d[$], q_b[$], q_o[$];
  initial begin q_d = '{0,0}; q_b = '{0,0}; q_o = '{0,0}; end

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_dir = 1;
      q_d = '{0,0}; q_b = '{0,0}; q_o = '{0,0};
    end else begin
      bit b, d, o;
      int nx;
      o = q_o[0];
      b = brake_ovr_en ? brake_ovr_val : q_b[0];
      d = dir_ovr_en ? dir_ovr_val : q_d[0];
      if (m_st == 0 || m_st == 3 || m_st == 4) m_dir = d;
      nx = m_st;
      if (o) nx = 0;
      else if (m_st == 0) nx = 4;
      else if (m_st == 4) begin
        if (b) nx = 2; else if (m_cnt == RC - 1) nx = 1;
      end else if (m_st == 1) begin
        if (b) nx = 2;
      end else if (m_st == 2) begin
        if (!b) nx = 1; else if (speed_meas <= brake_thresh) nx = 3;
      end else if (m_st == 3) begin
        if (!b) nx = 4;
      end
      m_cnt = (m_st == 4) ? m_cnt + 1 : 0;
      m_st = nx;
      void'(q_d.pop_front()); q_d.push_back(dir_pin);
      void'(q_b.pop_front()); q_b.push_back(brake_pin);
      void'(q_o.pop_front()); q_o.push_back(drvoff_pin);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    int tgt;
    tgt = (m_st == 1 || m_st == 4) ? speed_cmd : (m_st == 2) ? brake_thresh : 0;
    chk("R11 mode", mode, 1 << m_st);
    chk("R11 drive_en", drive_en, m_st != 0);
    chk("R4 speed_target", speed_target, tgt);
    chk("R9 phase_order", phase_order, m_dir ? 6'b000110 : 6'b001001);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PER * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(4);
    chk("R1 mode", mode, 5'b00001);
    chk("R1 drive_en", drive_en, 0);
    chk("R1 target", speed_target, 0);
    chk("R1 phase", phase_order, 6'b000110);
    rst = 0;
    step(1);
    chk("R4 restart", mode, 5'b10000);
    step(RC + 2);
    chk("R4 run", mode, 5'b00010);
    chk("R4 run target", speed_target, 1000);
    brake_pin = 1;
    step(2);
    chk("R2 no early", mode, 5'b00010);
    step(1);
    chk("R5 decel", mode, 5'b00100);
    chk("R5 decel target", speed_target, 300);
    step(8);
    chk("R5 wait thr", mode, 5'b00100);
    speed_meas = 300;
    step(1);
    chk("R5 brake", mode, 5'b01000);
    chk("R5 brake target", speed_target, 0);
    dir_pin = 0;
    step(10);
    chk("R6 held", mode, 5'b01000);
    chk("R10 latched in brake", phase_order, 6'b001001);
    brake_pin = 0;
    step(3);
    chk("R7 brake drop", mode, 5'b10000);
    step(RC + 2);
    chk("R4 run again", mode, 5'b00010);
    dir_pin = 1;
    step(6);
    chk("R10 hold in run", phase_order, 6'b001001);
    speed_meas = 2000;
    brake_pin = 1;
    step(5);
    brake_pin = 0;
    step(3);
    chk("R7 decel drop", mode, 5'b00010);
    brake_ovr_en = 1; brake_ovr_val = 1;
    step(1);
    chk("R8 brake ovr on", mode, 5'b00100);
    brake_ovr_val = 0; brake_pin = 1;
    step(4);
    chk("R8 brake ovr off", mode, 5'b00010);
    brake_ovr_en = 0; brake_pin = 0;
    step(4);
    drvoff_pin = 1;
    step(2);
    chk("R2 drvoff sync", mode, 5'b00010);
    step(1);
    chk("R3 coast", mode, 5'b00001);
    chk("R3 drive off", drive_en, 0);
    brake_pin = 1; dir_ovr_en = 1; dir_ovr_val = 1;
    step(6);
    chk("R3 brake in coast", mode, 5'b00001);
    chk("R8 dir ovr", phase_order, 6'b000110);
    drvoff_pin = 0;
    step(3);
    chk("R4 restart after off", mode, 5'b10000);
    step(1);
    chk("R3 pending brake", mode, 5'b00100);
    brake_pin = 0; dir_ovr_en = 0;
    step(RC + 6);
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 16 == 0) brake_pin = ~brake_pin;
      if ($urandom % 12 == 0) dir_pin = ~dir_pin;
      if ($urandom % 60 == 0) drvoff_pin = ~drvoff_pin;
      if ($urandom % 40 == 0) brake_ovr_en = ~brake_ovr_en;
      if ($urandom % 40 == 0) dir_ovr_en = ~dir_ovr_en;
      brake_ovr_val = $urandom; dir_ovr_val = $urandom;
      speed_meas = 290 + ($urandom % 20);
      step(1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule